// File: doc/BRIEF.md
# ADC Channel Read Sequencer

This block is a small bus master on the host side. It takes a single request that names one of sixteen converter channels, a two-bit range code and a flag for differential or single-ended input. It then runs the byte-wide register accesses needed to obtain one 16-bit conversion result. The converter exposes two identical windows of four byte registers. Channels 0–7 are reached through the window at address 0, and channels 8–15 through the window at address 4.

Each sample takes two command/convert rounds. The multiplexer settles during the first round and that result is discarded. After the second round, the sequencer reads the low and high data bytes. For the two bipolar range codes it shifts the result by half scale. The sample is returned with a one-cycle `done` pulse. If the converter never reports ready, the sequencer gives up after a bounded number of status polls and pulses `timeout` instead.

States, in order: `S_IDLE` (waiting; a request moves to `S_CMD_A`), `S_CMD_A` (first command write), `S_POLL_A_RQ`/`S_POLL_A_CK` (status read and check; ready goes to `S_CMD_B`, poll budget spent goes to `S_FAIL`, otherwise back to `S_POLL_A_RQ`), `S_CMD_B` (second command write), `S_POLL_B_RQ`/`S_POLL_B_CK` (same loop; ready goes to `S_LO_RQ`), `S_LO_RQ` (low byte read), `S_HI_RQ` (high byte read, low byte captured), `S_HI_CK` (high byte captured, sample formed), `S_DONE` (result pulse, back to `S_IDLE`), `S_FAIL` (timeout pulse, back to `S_IDLE`).

Top module: `adc_read_seq`

## Requirements
- R1: Channels 8–15 are accessed through the window at base address 4, and channels 0–7 through base 0. All accesses of one request use the same window.
- R2: The command byte has bit 7 = 1 for single-ended (req_diff = 0) and 0 for differential, bit 6 = channel bit 0, bits 5:4 = channel bits 2:1, bits 3:2 = range code, and bits 1:0 = 0.
- R3: The command byte is written to window offset 2. Ready is taken as bit 7 of a read of window offset 3, and polling repeats while that bit is 0.
- R4: Each request writes the same command byte exactly twice, waiting for ready after each write. Only data from the second conversion reaches the sample.
- R5: The sample's low byte comes from one read of window offset 0 and its high byte from one read of offset 1, both made after the second ready.
- R6: For range codes 0 and 1, the sample is the raw 16-bit word plus 0x8000 modulo 2^16. For range codes 2 and 3, the raw word is returned unchanged.
- R7: If POLL_LIMIT consecutive status reads in one wait all show not-ready, the sequencer pulses `timeout` for one cycle, does not pulse `done`, and makes no further bus access. POLL_LIMIT−1 not-ready reads followed by ready still completes.
- R8: `busy` is high from the cycle after a request is accepted in idle up to and including the result pulse. Requests made while busy are ignored.
- R9: `bus_wr` and `bus_rd` are single-cycle strobes and are never high together. Read data is taken in the cycle after the read strobe.
- R10: After reset, `busy`, `done`, `timeout`, `bus_wr` and `bus_rd` are 0 and `sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_chan | input | 4 | Channel number 0–15 |
| req_range | input | 2 | Range code; 0 and 1 are bipolar |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse; `sample` is valid |
| timeout | output | 1 | One-cycle pulse; ready never seen |
| sample | output | 16 | Last completed sample |
| bus_addr | output | 4 | Register address (window base + offset) |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Registered read data, valid the cycle after `bus_rd` |

## Verification
The bench builds the sequencer with POLL_LIMIT = 4. This keeps the timeout boundary within a few cycles, so both the last successful poll count (3 not-ready reads) and the first failing one (4) are driven directly. With the limit this small, all 128 combinations of channel, range and input mode are swept, together with several ready delays. The converter model in the bench returns a junk word for the first conversion of each request and a word derived from the window and command for the second. Any mix-up of conversion order, window or command fields therefore shows up in the returned sample.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_A,
        S_POLL_A_RQ,
        S_POLL_A_CK,
        S_CMD_B,
        S_POLL_B_RQ,
        S_POLL_B_CK,
        S_LO_RQ,
        S_HI_RQ,
        S_HI_CK,
        S_DONE,
        S_FAIL
    } seq_state_t;

    // register offsets inside one converter window
    localparam int OFS_DATA_LO = 0;
    localparam int OFS_DATA_HI = 1;
    localparam int OFS_COMMAND = 2;
    localparam int OFS_STATUS  = 3;
    localparam int READY_BIT   = 7;

endpackage

// File: rtl/adc_cmd_encode.sv
module adc_cmd_encode #(
    parameter int CHAN_W     = 4,
    parameter int RANGE_W    = 2,
    parameter int BYTE_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int WIN_STRIDE = 4
) (
    input  logic [CHAN_W-1:0]  chan,
    input  logic [RANGE_W-1:0] range_code,
    input  logic               diff,
    output logic [BYTE_W-1:0]  cmd_byte,
    output logic [ADDR_W-1:0]  win_base
);
    // the top channel bit selects the window; the rest address inside it
    localparam int LOCAL_W = CHAN_W - 1;

    logic [LOCAL_W-1:0] local_chan;

    assign local_chan = chan[LOCAL_W-1:0];

    always_comb begin
        cmd_byte      = '0;
        cmd_byte[7]   = ~diff;
        cmd_byte[6]   = local_chan[0];
        cmd_byte[5:4] = local_chan[2:1];
        cmd_byte[3:2] = range_code[1:0];
    end

    assign win_base = chan[CHAN_W-1] ? ADDR_W'(WIN_STRIDE) : '0;

endmodule

// File: rtl/adc_poll_timer.sv
module adc_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // true while the poll being checked is the last one allowed
    assign expired = (count == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/adc_sample_fix.sv
module adc_sample_fix #(
    parameter int BYTE_W  = 8,
    parameter int RANGE_W = 2
) (
    input  logic [BYTE_W-1:0]    lo_byte,
    input  logic [BYTE_W-1:0]    hi_byte,
    input  logic [RANGE_W-1:0]   range_code,
    output logic [2*BYTE_W-1:0]  sample
);
    localparam int SAMPLE_W = 2 * BYTE_W;
    localparam logic [SAMPLE_W-1:0] HALF_SCALE = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic bipolar;

    assign bipolar = (range_code < RANGE_W'(2));
    assign sample  = {hi_byte, lo_byte} + (bipolar ? HALF_SCALE : '0);

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq #(
    parameter int CHAN_W     = 4,
    parameter int RANGE_W    = 2,
    parameter int BYTE_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int WIN_STRIDE = 4,
    parameter int POLL_LIMIT = 100000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [CHAN_W-1:0]     req_chan,
    input  logic [RANGE_W-1:0]    req_range,
    input  logic                  req_diff,
    output logic                  busy,
    output logic                  done,
    output logic                  timeout,
    output logic [2*BYTE_W-1:0]   sample,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_wr,
    output logic [BYTE_W-1:0]     bus_wdata,
    output logic                  bus_rd,
    input  logic [BYTE_W-1:0]     bus_rdata
);
    import adc_seq_pkg::*;

    localparam int SAMPLE_W = 2 * BYTE_W;

    seq_state_t state, state_nx;

    logic [CHAN_W-1:0]   chan_q;
    logic [RANGE_W-1:0]  range_q;
    logic                diff_q;
    logic [BYTE_W-1:0]   lo_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic [SAMPLE_W-1:0] sample_fixed;
    logic [BYTE_W-1:0]   cmd_byte;
    logic [ADDR_W-1:0]   win_base;
    logic [ADDR_W-1:0]   ofs;
    logic                ready;
    logic                poll_clear;
    logic                poll_step;
    logic                poll_expired;
    logic                accept;

    assign accept = (state == S_IDLE) && req_valid;
    assign ready  = bus_rdata[READY_BIT];

    adc_cmd_encode #(
        .CHAN_W(CHAN_W), .RANGE_W(RANGE_W), .BYTE_W(BYTE_W),
        .ADDR_W(ADDR_W), .WIN_STRIDE(WIN_STRIDE)
    ) i_encode (
        .chan(chan_q), .range_code(range_q), .diff(diff_q),
        .cmd_byte(cmd_byte), .win_base(win_base)
    );

    adc_poll_timer #(.LIMIT(POLL_LIMIT)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear(poll_clear),
        .step(poll_step), .expired(poll_expired)
    );

    adc_sample_fix #(.BYTE_W(BYTE_W), .RANGE_W(RANGE_W)) i_fix (
        .lo_byte(lo_q), .hi_byte(bus_rdata), .range_code(range_q),
        .sample(sample_fixed)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q   <= '0;
            range_q  <= '0;
            diff_q   <= 1'b0;
            lo_q     <= '0;
            sample_q <= '0;
        end else begin
            if (accept) begin
                chan_q  <= req_chan;
                range_q <= req_range;
                diff_q  <= req_diff;
            end
            if (state == S_HI_RQ) begin
                lo_q <= bus_rdata;
            end
            if (state == S_HI_CK) begin
                sample_q <= sample_fixed;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (req_valid) state_nx = S_CMD_A;
            S_CMD_A:     state_nx = S_POLL_A_RQ;
            S_POLL_A_RQ: state_nx = S_POLL_A_CK;
            S_POLL_A_CK: begin
                if (ready)             state_nx = S_CMD_B;
                else if (poll_expired) state_nx = S_FAIL;
                else                   state_nx = S_POLL_A_RQ;
            end
            S_CMD_B:     state_nx = S_POLL_B_RQ;
            S_POLL_B_RQ: state_nx = S_POLL_B_CK;
            S_POLL_B_CK: begin
                if (ready)             state_nx = S_LO_RQ;
                else if (poll_expired) state_nx = S_FAIL;
                else                   state_nx = S_POLL_B_RQ;
            end
            S_LO_RQ:     state_nx = S_HI_RQ;
            S_HI_RQ:     state_nx = S_HI_CK;
            S_HI_CK:     state_nx = S_DONE;
            S_DONE:      state_nx = S_IDLE;
            S_FAIL:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        ofs        = '0;
        done       = 1'b0;
        timeout    = 1'b0;
        poll_clear = 1'b0;
        poll_step  = 1'b0;
        unique case (state)
            S_CMD_A, S_CMD_B: begin
                bus_wr     = 1'b1;
                ofs        = ADDR_W'(OFS_COMMAND);
                poll_clear = 1'b1;
            end
            S_POLL_A_RQ, S_POLL_B_RQ: begin
                bus_rd = 1'b1;
                ofs    = ADDR_W'(OFS_STATUS);
            end
            S_POLL_A_CK, S_POLL_B_CK: poll_step = ~ready;
            S_LO_RQ: begin
                bus_rd = 1'b1;
                ofs    = ADDR_W'(OFS_DATA_LO);
            end
            S_HI_RQ: begin
                bus_rd = 1'b1;
                ofs    = ADDR_W'(OFS_DATA_HI);
            end
            S_DONE:  done    = 1'b1;
            S_FAIL:  timeout = 1'b1;
            default: ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign bus_addr  = win_base | ofs;
    assign bus_wdata = cmd_byte;
    assign sample    = sample_q;

endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              timeout,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd
);
    // R9: one strobe at a time
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R9: strobes last a single cycle
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> !(bus_wr && $past(bus_wr)) && !(bus_rd && $past(bus_rd) && $stable(bus_addr)));

    // R3: writes only ever go to the command offset
    p_cmd_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr[1:0] == 2'd2));

    // R1: the window does not change inside a request
    p_window_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr[ADDR_W-1:2]));

    // R7: a request ends in exactly one kind of result
    p_result_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    // R8: busy drops right after the result pulse
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |=> !busy);

    // R8: busy only starts from a request
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

bind adc_read_seq adc_read_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .done(done), .timeout(timeout), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd)
);

// File: tb/test_adc_read_seq.sv
module test_adc_read_seq;

    localparam int POLL_LIMIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_chan = '0;
    logic [1:0]  req_range = '0;
    logic        req_diff = 1'b0;
    logic        busy, done, timeout, bus_wr, bus_rd;
    logic [15:0] sample;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    adc_read_seq #(.POLL_LIMIT(POLL_LIMIT)) i_adc_read_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_range(req_range), .req_diff(req_diff), .busy(busy), .done(done),
        .timeout(timeout), .sample(sample), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // ---------------- converter model ----------------
    int         delay_cfg = 0;
    int         pend = 0;
    int         wr_cnt = 0, lo_cnt = 0, hi_cnt = 0, stat_cnt = 0;
    logic [3:0] wr_addr [2];
    logic [7:0] wr_data [2];
    logic [15:0] conv_word [2];
    int         conv_num [2];

    function automatic logic [15:0] model_word(input int w, input logic [7:0] cmd);
        return {cmd ^ (w != 0 ? 8'hA5 : 8'h00), ~cmd};
    endfunction

    always @(posedge clk) begin
        if (req_valid && !busy) begin
            wr_cnt = 0; lo_cnt = 0; hi_cnt = 0; stat_cnt = 0;
            conv_num[0] = 0; conv_num[1] = 0;
        end
        if (bus_wr) begin
            automatic int w = bus_addr[2];
            if (wr_cnt < 2) begin
                wr_addr[wr_cnt] = bus_addr;
                wr_data[wr_cnt] = bus_wdata;
            end
            wr_cnt++;
            conv_num[w]++;
            conv_word[w] = (conv_num[w] == 2) ? model_word(w, bus_wdata) : 16'hBAD0;
            pend = delay_cfg;
        end
        if (bus_rd) begin
            automatic int w = bus_addr[2];
            case (bus_addr[1:0])
                2'd3: begin
                    stat_cnt++;
                    if (pend > 0) begin
                        bus_rdata <= 8'h00;
                        pend--;
                    end else begin
                        bus_rdata <= 8'h80;
                    end
                end
                2'd0: begin lo_cnt++; bus_rdata <= conv_word[w][7:0];  end
                2'd1: begin hi_cnt++; bus_rdata <= conv_word[w][15:8]; end
                default: bus_rdata <= 8'h00;
            endcase
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input int c, input int r, input bit d);
        return 8'((d ? 0 : 128) + (c % 2) * 64 + ((c % 8) / 2) * 16 + r * 4);
    endfunction

    // runs one request; result flags returned
    task automatic run_req(input int c, input int r, input bit d, input int delay,
                           output bit got_done, output bit got_to);
        delay_cfg = delay;
        @(negedge clk);
        req_valid = 1'b1; req_chan = 4'(c); req_range = 2'(r); req_diff = d;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0; got_to = 1'b0;
        for (int i = 0; i < 500; i++) begin
            if (done || timeout) break;
            @(negedge clk);
        end
        got_done = done; got_to = timeout;
        if (!got_done && !got_to) chk(1'b0, "R8", "no result pulse", 0, 1);
    endtask

    task automatic check_ok(input int c, input int r, input bit d, input bit got_done);
        logic [7:0]  cmd = exp_cmd(c, r, d);
        logic [3:0]  base = (c >= 8) ? 4'd4 : 4'd0;
        logic [15:0] exp_s = model_word(c / 8, cmd) + ((r < 2) ? 16'h8000 : 16'h0000);
        chk(got_done, "R8", "done pulse", 32'(got_done), 1);
        chk(sample == exp_s, "R6", "sample value", sample, exp_s);
        chk(wr_cnt == 2, "R4", "command write count", wr_cnt, 2);
        chk(wr_data[0] == cmd && wr_data[1] == cmd, "R2", "command byte",
            {wr_data[0], wr_data[1]}, {cmd, cmd});
        chk(wr_addr[0] == (base | 4'd2) && wr_addr[1] == (base | 4'd2), "R1",
            "command address", {wr_addr[0], wr_addr[1]}, {base | 4'd2, base | 4'd2});
        chk(lo_cnt == 1 && hi_cnt == 1, "R5", "data byte reads", {lo_cnt[15:0], hi_cnt[15:0]}, 32'h0001_0001);
        @(negedge clk);
        chk(!busy && !done, "R8", "idle after done", {busy, done}, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        bit gd, gt;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !timeout && !bus_wr && !bus_rd, "R10", "reset outputs",
            {busy, done, timeout, bus_wr, bus_rd}, 0);
        chk(sample == 16'h0, "R10", "reset sample", sample, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_wr && !bus_rd, "R10", "idle without request", {busy, bus_wr, bus_rd}, 0);

        // sweep: every channel, range and mode (R1 R2 R4 R5 R6)
        for (int c = 0; c < 16; c++)
            for (int r = 0; r < 4; r++)
                for (int d = 0; d < 2; d++) begin
                    run_req(c, r, d[0], (c + r + d) % 3, gd, gt);
                    check_ok(c, r, d[0], gd);
                end

        // R3: status polled until ready; 2 not-ready reads per wait
        run_req(5, 2, 1'b0, 2, gd, gt);
        chk(stat_cnt == 6, "R3", "status reads with delay 2", stat_cnt, 6);
        check_ok(5, 2, 1'b0, gd);

        // R7 boundary: POLL_LIMIT-1 not-ready reads still completes
        run_req(9, 0, 1'b1, POLL_LIMIT - 1, gd, gt);
        chk(stat_cnt == 2 * POLL_LIMIT, "R7", "status reads at limit-1", stat_cnt, 2 * POLL_LIMIT);
        check_ok(9, 0, 1'b1, gd);

        // R7: POLL_LIMIT not-ready reads gives timeout
        run_req(14, 3, 1'b0, POLL_LIMIT, gd, gt);
        chk(gt && !gd, "R7", "timeout instead of done", {gt, gd}, 2'b10);
        chk(stat_cnt == POLL_LIMIT, "R7", "status reads before timeout", stat_cnt, POLL_LIMIT);
        repeat (6) @(negedge clk);
        chk(wr_cnt == 1 && lo_cnt == 0 && hi_cnt == 0 && stat_cnt == POLL_LIMIT, "R7",
            "no bus access after timeout", wr_cnt, 1);
        chk(!busy, "R8", "idle after timeout", busy, 0);

        // R8: request while busy is ignored
        delay_cfg = 1;
        @(negedge clk);
        req_valid = 1'b1; req_chan = 4'd3; req_range = 2'd3; req_diff = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy, "R8", "busy during request", busy, 1);
        req_valid = 1'b1; req_chan = 4'd12; req_range = 2'd0; req_diff = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        gd = 1'b0;
        for (int i = 0; i < 500; i++) begin
            if (done) begin gd = 1'b1; break; end
            @(negedge clk);
        end
        check_ok(3, 3, 1'b1, gd);
        repeat (4) @(negedge clk);
        chk(!busy && wr_cnt == 2, "R8", "ignored request not started later", {busy, 8'(wr_cnt)}, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule